// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a small 16-bit processor whose instructions are all two bytes wide. In every cycle it chooses the next fetch address and registers it. Without a request, the PC moves to the next sequential instruction. A conditional branch tests a three-bit condition against the zero, negative and overflow flags left by the most recent arithmetic or compare operation. When the condition holds, the PC moves by a signed instruction count relative to the following instruction. An absolute jump loads the PC from a register operand.

The next PC and the taken flag are combinational views of the current cycle's decision. The PC register takes the next PC at the following clock edge. If a branch names the unassigned condition code, the branch is not taken and a one-cycle illegal-condition pulse is raised so that the surrounding core can trap. Flag generation, fetch and pipeline flushing belong to neighbouring blocks.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes 0 at that edge.
- R2: With `br_req` and `jmp_req` both low, `next_pc` equals `pc + 2` modulo 2^16, `taken` is 0, and `pc` takes that value at the next edge. From 0xFFFE the PC wraps to 0x0000.
- R3: Condition code 000 (equal) is satisfied when `flag_z` is 1. Condition code 001 (not equal) is satisfied when `flag_z` is 0.
- R4: The signed codes use these flags. 010 (greater) needs `flag_z`=0 and `flag_n`==`flag_v`. 011 (greater-or-equal) needs `flag_n`==`flag_v`. 100 (less) needs `flag_n`!=`flag_v`. 101 (less-or-equal) needs `flag_z`=1 or `flag_n`!=`flag_v`.
- R5: Condition code 111 is always satisfied, whatever the flags are.
- R6: A branch with condition code 110 is not taken. It sets `illegal_cond` high for that cycle. `illegal_cond` is 0 in every other case.
- R7: When a branch is taken, `next_pc` = `pc` + 2 + 2 × `offset`, modulo 2^16. Here `offset` is read as an 8-bit two's-complement value (range −128..127). When a branch is not taken, `next_pc` = `pc` + 2. `taken` is 1 exactly when the condition is satisfied.
- R8: A jump sets `taken` to 1. It sets `next_pc` to `jreg` with bit 0 forced to 0.
- R9: When `jmp_req` and `br_req` are both high, the jump decides the result. The condition and the offset have no effect, and `illegal_cond` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_req | input | 1 | Conditional branch request this cycle |
| jmp_req | input | 1 | Absolute jump request this cycle |
| cond | input | 3 | Branch condition code |
| offset | input | 8 | Signed branch displacement in instructions |
| jreg | input | 16 | Register value used as the jump target |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Signed overflow flag |
| pc | output | 16 | Current program counter |
| next_pc | output | 16 | Address the PC loads at the next edge |
| taken | output | 1 | Branch or jump redirects the PC this cycle |
| illegal_cond | output | 1 | Branch named the reserved condition code |

## Verification
The bench builds the unit with its default 16-bit PC and 8-bit offset. These widths are small enough that every condition code can be swept against all eight flag combinations. All 256 offsets can be swept with the unconditional code, so both extremes of the displacement range, and wrap-around of the PC in both directions, are covered. Jumps use odd targets, the top address and a request that coincides with a branch. The expected addresses come from integer arithmetic on a model PC that the bench keeps.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [2:0] {
        CC_EQ  = 3'b000,
        CC_NE  = 3'b001,
        CC_GT  = 3'b010,
        CC_GE  = 3'b011,
        CC_LT  = 3'b100,
        CC_LE  = 3'b101,
        CC_RSV = 3'b110,
        CC_ALW = 3'b111
    } cond_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
    } flags_t;

    typedef enum logic [1:0] {
        SEL_SEQ = 2'd0,
        SEL_BR  = 2'd1,
        SEL_JMP = 2'd2
    } sel_e;

    function automatic logic cond_hit(cond_e c, flags_t f);
        logic sless;
        sless = f.n ^ f.v;
        unique case (c)
            CC_EQ:   return f.z;
            CC_NE:   return !f.z;
            CC_GT:   return !f.z && !sless;
            CC_GE:   return !sless;
            CC_LT:   return sless;
            CC_LE:   return f.z || sless;
            CC_ALW:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval
    import pcu_pkg::*;
(
    input  logic [2:0] cond,
    input  flags_t     flags,
    output logic       hit,
    output logic       reserved
);
    cond_e code;

    always_comb begin
        code     = cond_e'(cond);
        hit      = cond_hit(code, flags);
        reserved = (code == CC_RSV);
    end

    always_comb begin
        AST_RSV_NEVER_HITS: assert (!(reserved && hit)); // R6
    end
endmodule

// File: rtl/pcu_target_gen.sv
module pcu_target_gen #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [PC_W-1:0]  jreg,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  br_pc,
    output logic [PC_W-1:0]  jmp_pc
);
    localparam int EXT_W = PC_W - OFF_W - 1;
    localparam logic [PC_W-1:0] STEP = PC_W'(2);

    logic [PC_W-1:0] disp;

    always_comb begin
        disp   = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
        seq_pc = pc + STEP;
        br_pc  = seq_pc + disp;
        jmp_pc = {jreg[PC_W-1:1], 1'b0};
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_req,
    input  logic             jmp_req,
    input  logic [2:0]       cond,
    input  logic [OFF_W-1:0] offset,
    input  logic [PC_W-1:0]  jreg,
    input  logic             flag_z,
    input  logic             flag_n,
    input  logic             flag_v,
    output logic [PC_W-1:0]  pc,
    output logic [PC_W-1:0]  next_pc,
    output logic             taken,
    output logic             illegal_cond
);
    flags_t          flags;
    logic            hit;
    logic            reserved;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] br_pc;
    logic [PC_W-1:0] jmp_pc;
    sel_e            sel;
    logic [PC_W-1:0] pc_q;

    assign flags = '{z: flag_z, n: flag_n, v: flag_v};

    pcu_cond_eval u_cond (
        .cond     (cond),
        .flags    (flags),
        .hit      (hit),
        .reserved (reserved)
    );

    pcu_target_gen #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc     (pc_q),
        .offset (offset),
        .jreg   (jreg),
        .seq_pc (seq_pc),
        .br_pc  (br_pc),
        .jmp_pc (jmp_pc)
    );

    always_comb begin
        if (jmp_req)            sel = SEL_JMP;
        else if (br_req && hit) sel = SEL_BR;
        else                    sel = SEL_SEQ;
    end

    always_comb begin
        unique case (sel)
            SEL_JMP: next_pc = jmp_pc;
            SEL_BR:  next_pc = br_pc;
            default: next_pc = seq_pc;
        endcase
        taken        = (sel != SEL_SEQ);
        illegal_cond = br_req && !jmp_req && reserved;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= next_pc;
    end

    assign pc = pc_q;

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> pc == '0); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!br_req && !jmp_req) |=> pc == $past(pc) + PC_W'(2)); // R2
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_req && !jmp_req && cond == 3'b111) |-> taken); // R5
    AST_RSV_PULSE: assert property (@(posedge clk) disable iff (rst)
        (br_req && !jmp_req && cond == 3'b110) |-> (!taken && illegal_cond)); // R6
    AST_JMP_EVEN: assert property (@(posedge clk) disable iff (rst)
        jmp_req |-> (taken && !next_pc[0] && next_pc[PC_W-1:1] == jreg[PC_W-1:1])); // R8
    AST_JMP_NO_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        jmp_req |-> !illegal_cond); // R9
endmodule

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_req = 1'b0;
    logic        jmp_req = 1'b0;
    logic [2:0]  cond = 3'b0;
    logic [7:0]  offset = 8'h0;
    logic [15:0] jreg = 16'h0;
    logic        flag_z = 1'b0;
    logic        flag_n = 1'b0;
    logic        flag_v = 1'b0;
    logic [15:0] pc;
    logic [15:0] next_pc;
    logic        taken;
    logic        illegal_cond;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] mpc;
    bit done = 0;

    always #10 clk = ~clk;

    pc_next_unit u0 (
        .clk(clk), .rst(rst), .br_req(br_req), .jmp_req(jmp_req),
        .cond(cond), .offset(offset), .jreg(jreg),
        .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
        .pc(pc), .next_pc(next_pc), .taken(taken), .illegal_cond(illegal_cond)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit model_hit(int c, bit z, bit n, bit v);
        case (c)
            0: return z;
            1: return !z;
            2: return !z && (n == v);
            3: return n == v;
            4: return n != v;
            5: return z || (n != v);
            7: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // inputs already applied during the low phase; check outputs, clock, check pc
    task automatic step(string tag, int exp_next, bit exp_taken, bit exp_ill);
        #1;
        cmp(tag, "next_pc", int'(next_pc), exp_next);
        cmp(tag, "taken", int'(taken), int'(exp_taken));
        cmp(tag, "illegal_cond", int'(illegal_cond), int'(exp_ill));
        @(posedge clk);
        #1;
        mpc = 16'(exp_next);
        cmp(tag, "pc", int'(pc), int'(mpc));
        @(negedge clk);
    endtask

    task automatic idle;
        br_req = 0; jmp_req = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1;
        cmp("R1", "pc", int'(pc), 0);
        rst = 0;
        mpc = 16'h0;

        // R2: plain sequential steps
        idle();
        for (int i = 0; i < 4; i++) step("R2", (int'(mpc) + 2) & 16'hFFFF, 0, 0);

        // R3 R4 R5 R6 R7: every code against every flag set
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 8; f++) begin
                int so;
                bit h;
                string tg;
                br_req = 1; jmp_req = 0;
                cond = 3'(c);
                flag_z = f[2]; flag_n = f[1]; flag_v = f[0];
                offset = 8'(c * 37 + f * 11);
                so = (int'(offset) >= 128) ? int'(offset) - 256 : int'(offset);
                h = model_hit(c, f[2], f[1], f[0]);
                tg = (c < 2) ? "R3" : (c < 6) ? "R4" : (c == 6) ? "R6" : "R5";
                step(tg, h ? ((int'(mpc) + 2 + 2 * so) & 16'hFFFF) : ((int'(mpc) + 2) & 16'hFFFF),
                     h, c == 6);
            end
        end

        // R7: all offsets with the unconditional code
        for (int o = 0; o < 256; o++) begin
            int so;
            br_req = 1; jmp_req = 0; cond = 3'b111;
            offset = 8'(o);
            so = (o >= 128) ? o - 256 : o;
            step("R7", (int'(mpc) + 2 + 2 * so) & 16'hFFFF, 1, 0);
        end

        // R8: jumps, including odd targets
        idle();
        jmp_req = 1;
        jreg = 16'h1235; step("R8", 16'h1234, 1, 0);
        jreg = 16'hFFFF; step("R8", 16'hFFFE, 1, 0);
        jreg = 16'h8000; step("R8", 16'h8000, 1, 0);
        jreg = 16'h0001; step("R8", 16'h0000, 1, 0);

        // R2: wrap from top of the address space
        jreg = 16'hFFFE; step("R8", 16'hFFFE, 1, 0);
        idle();
        step("R2", 16'h0000, 0, 0);

        // R9: jump with a concurrent branch, including reserved code
        br_req = 1; jmp_req = 1; cond = 3'b111; offset = 8'h40; jreg = 16'h0421;
        step("R9", 16'h0420, 1, 0);
        cond = 3'b110; jreg = 16'h7777;
        step("R9", 16'h7776, 1, 0);

        // R6: reserved code alone, then back to normal
        jmp_req = 0; cond = 3'b110; offset = 8'h7F;
        step("R6", (int'(mpc) + 2) & 16'hFFFF, 0, 1);
        idle();
        step("R6", (int'(mpc) + 2) & 16'hFFFF, 0, 0);

        // R1: reset mid-run
        rst = 1;
        @(posedge clk); #1;
        cmp("R1", "pc", int'(pc), 0);
        @(negedge clk);
        rst = 0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule